// File: doc/BRIEF.md
# Dual FIFO with Level-Driven Service Requests

This block holds two synchronous first-in first-out buffers side by side. The transmit buffer is filled from the register side and drained by a serial shift engine. The receive buffer is filled by the shift engine and drained from the register side. Each buffer reports how many entries it holds, plus full and empty flags. Its head entry is always visible on the read data port, and a pop retires that entry.

Each direction raises its own level-sensitive service request. There are two modes. In per-element mode, transmit asks for data whenever any entry is free, and receive asks to be read whenever any entry is waiting. In threshold mode, transmit asks while its fill level is at or below a programmed threshold, so that room for a batch exists. Receive asks only once its fill level is above its threshold. A third request reports misuse: a push into a full buffer or a pop from an empty one. That request stays set until it is cleared by a clear strobe.

Top module: `fifo_irq_pair`

## Requirements
- R1: Each buffer returns entries in the order they were accepted. The oldest entry is presented on the read data port whenever the buffer is not empty.
- R2: The level output counts the held entries, from 0 to DEPTH (default 16). Full is high at DEPTH and empty is high at 0. The level changes on the clock edge that takes a push or a pop. A push and a pop in the same cycle leave the level unchanged.
- R3: A push into a full buffer is dropped and leaves the level and contents unchanged. A pop from an empty buffer leaves the level unchanged.
- R4: Per-element mode (mode input 0) for transmit: when enabled, the transmit request is high while the transmit level is below DEPTH.
- R5: Threshold mode (mode input 1) for transmit: when enabled, the transmit request is high while the transmit level is less than or equal to the 4-bit threshold.
- R6: Per-element mode (mode input 0) for receive: when enabled, the receive request is high while the receive level is at least 1.
- R7: Threshold mode (mode input 1) for receive: when enabled, the receive request is high only while the receive level is strictly greater than the 4-bit threshold.
- R8: A request whose enable input is low stays low. This applies to the transmit, receive and error requests.
- R9: A pending error bit sets on any overflow or underflow of either buffer. It holds until a cycle with the clear strobe high and no new error; if both happen in the same cycle, the set wins. The error request is the pending bit gated by its enable.
- R10: All three requests are registered. They reflect the level and configuration of the previous cycle. After reset both buffers are empty and all requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txPushReq | input | 1 | Write a transmit entry |
| txPushData | input | DW | Transmit entry to write |
| txPopReq | input | 1 | Shift engine retires the transmit head |
| txPopData | output | DW | Transmit head entry |
| txLevel | output | AW+1 | Transmit fill level |
| txFull | output | 1 | Transmit buffer full |
| txEmpty | output | 1 | Transmit buffer empty |
| rxPushReq | input | 1 | Shift engine writes a received entry |
| rxPushData | input | DW | Received entry to write |
| rxPopReq | input | 1 | Register side retires the receive head |
| rxPopData | output | DW | Receive head entry |
| rxLevel | output | AW+1 | Receive fill level |
| rxFull | output | 1 | Receive buffer full |
| rxEmpty | output | 1 | Receive buffer empty |
| txIrqEn | input | 1 | Transmit request enable |
| txBatch | input | 1 | Transmit mode: 0 per element, 1 threshold |
| txThresh | input | AW | Transmit threshold |
| rxIrqEn | input | 1 | Receive request enable |
| rxBatch | input | 1 | Receive mode: 0 per element, 1 threshold |
| rxThresh | input | AW | Receive threshold |
| errIrqEn | input | 1 | Error request enable |
| errClear | input | 1 | Clear strobe for the pending error |
| txIrq | output | 1 | Transmit service request |
| rxIrq | output | 1 | Receive service request |
| errIrq | output | 1 | Error service request |

## Verification
The assertions rely on several properties of the inputs. Requests are synchronous to the clock. Threshold and mode inputs may change in any cycle. Overflow and underflow are legal stimulus and are not treated as protocol violations, because the block is required to absorb them. The stimulus changes inputs only on the falling edge. It provokes overflow and underflow on purpose, only at chosen points where the model expects them. It never pops a buffer in the same cycle as the first push into it, so that the reference queue and the design agree on which pops are accepted.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifo_strobe_t;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned TX_IDX  = 0;
  localparam int unsigned RX_IDX  = 1;
endpackage

// File: rtl/fifo_irq_store.sv
module fifo_irq_store
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifo_strobe_t  strobe,
  input  logic [DW-1:0] pushData,
  output logic [DW-1:0] popData,
  output logic [LW-1:0] level
);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] count;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign popData = mem[rdPtr];
  assign level   = count;

  // R2: level never exceeds the depth
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_LVL);

  // R2: a lone push grows the level by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push && !strobe.pop |=> count == $past(count) + 1'b1);

  // R3: control never retires an entry from an empty store
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> count != '0);

  // R3: control never writes into a full store
  a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> count != FULL_LVL);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          txPushReq,
  input  logic          txPopReq,
  input  logic          rxPushReq,
  input  logic          rxPopReq,
  input  logic [LW-1:0] txLevel,
  input  logic [LW-1:0] rxLevel,
  input  logic          txIrqEn,
  input  logic          txBatch,
  input  logic [AW-1:0] txThresh,
  input  logic          rxIrqEn,
  input  logic          rxBatch,
  input  logic [AW-1:0] rxThresh,
  input  logic          errIrqEn,
  input  logic          errClear,
  output fifo_strobe_t  txStrb,
  output fifo_strobe_t  rxStrb,
  output logic          txFull,
  output logic          txEmpty,
  output logic          rxFull,
  output logic          rxEmpty,
  output logic          txIrq,
  output logic          rxIrq,
  output logic          errIrq
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic txWant, rxWant, fault, errPend;

  always_comb begin
    txFull  = (txLevel == FULL_LVL);
    txEmpty = (txLevel == '0);
    rxFull  = (rxLevel == FULL_LVL);
    rxEmpty = (rxLevel == '0);

    txStrb.push = txPushReq && !txFull;
    txStrb.pop  = txPopReq  && !txEmpty;
    rxStrb.push = rxPushReq && !rxFull;
    rxStrb.pop  = rxPopReq  && !rxEmpty;

    fault = (txPushReq && txFull) || (txPopReq && txEmpty) ||
            (rxPushReq && rxFull) || (rxPopReq && rxEmpty);

    txWant = txBatch ? (txLevel <= {1'b0, txThresh}) : !txFull;
    rxWant = rxBatch ? (rxLevel >  {1'b0, rxThresh}) : !rxEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPend <= 1'b0;
      txIrq   <= 1'b0;
      rxIrq   <= 1'b0;
      errIrq  <= 1'b0;
    end else begin
      if (fault)         errPend <= 1'b1;
      else if (errClear) errPend <= 1'b0;
      txIrq  <= txIrqEn  && txWant;
      rxIrq  <= rxIrqEn  && rxWant;
      errIrq <= errIrqEn && errPend;
    end
  end

  // R8: disabled requests stay low
  a_r8_tx_gate: assert property (@(posedge clk) disable iff (!rstN)
    !txIrqEn |=> !txIrq);
  a_r8_rx_gate: assert property (@(posedge clk) disable iff (!rstN)
    !rxIrqEn |=> !rxIrq);

  // R9: pending error holds until cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errPend && !errClear |=> errPend);

  // R9: overflow on transmit records an error
  a_r9_overflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    txPushReq && txFull |=> errPend);

  // R6: waiting receive data raises the request in per-element mode
  a_r6_rx_single: assert property (@(posedge clk) disable iff (!rstN)
    rxIrqEn && !rxBatch && !rxEmpty |=> rxIrq);

  // R4: a full transmit buffer drops the per-element request
  a_r4_tx_single_full: assert property (@(posedge clk) disable iff (!rstN)
    !txBatch && txFull |=> !txIrq);
endmodule

// File: rtl/fifo_irq_pair.sv
module fifo_irq_pair
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          txPushReq,
  input  logic [DW-1:0] txPushData,
  input  logic          txPopReq,
  output logic [DW-1:0] txPopData,
  output logic [LW-1:0] txLevel,
  output logic          txFull,
  output logic          txEmpty,
  input  logic          rxPushReq,
  input  logic [DW-1:0] rxPushData,
  input  logic          rxPopReq,
  output logic [DW-1:0] rxPopData,
  output logic [LW-1:0] rxLevel,
  output logic          rxFull,
  output logic          rxEmpty,
  input  logic          txIrqEn,
  input  logic          txBatch,
  input  logic [AW-1:0] txThresh,
  input  logic          rxIrqEn,
  input  logic          rxBatch,
  input  logic [AW-1:0] rxThresh,
  input  logic          errIrqEn,
  input  logic          errClear,
  output logic          txIrq,
  output logic          rxIrq,
  output logic          errIrq
);
  fifo_strobe_t  strb    [NUM_DIR];
  logic [DW-1:0] inData  [NUM_DIR];
  logic [DW-1:0] outData [NUM_DIR];
  logic [LW-1:0] lvl     [NUM_DIR];

  assign inData[TX_IDX] = txPushData;
  assign inData[RX_IDX] = rxPushData;
  assign txPopData = outData[TX_IDX];
  assign rxPopData = outData[RX_IDX];
  assign txLevel   = lvl[TX_IDX];
  assign rxLevel   = lvl[RX_IDX];

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    fifo_irq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strb[d]),
      .pushData (inData[d]),
      .popData  (outData[d]),
      .level    (lvl[d])
    );
  end

  fifo_irq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txPushReq (txPushReq),
    .txPopReq  (txPopReq),
    .rxPushReq (rxPushReq),
    .rxPopReq  (rxPopReq),
    .txLevel   (lvl[TX_IDX]),
    .rxLevel   (lvl[RX_IDX]),
    .txIrqEn   (txIrqEn),
    .txBatch   (txBatch),
    .txThresh  (txThresh),
    .rxIrqEn   (rxIrqEn),
    .rxBatch   (rxBatch),
    .rxThresh  (rxThresh),
    .errIrqEn  (errIrqEn),
    .errClear  (errClear),
    .txStrb    (strb[TX_IDX]),
    .rxStrb    (strb[RX_IDX]),
    .txFull    (txFull),
    .txEmpty   (txEmpty),
    .rxFull    (rxFull),
    .rxEmpty   (rxEmpty),
    .txIrq     (txIrq),
    .rxIrq     (rxIrq),
    .errIrq    (errIrq)
  );
endmodule

// File: tb/sim_fifo_irq_pair.sv
module sim_fifo_irq_pair;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txPushReq = 0, txPopReq = 0, rxPushReq = 0, rxPopReq = 0;
  logic [DW-1:0] txPushData = '0, rxPushData = '0;
  logic [DW-1:0] txPopData, rxPopData;
  logic [LW-1:0] txLevel, rxLevel;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txIrqEn = 0, txBatch = 0, rxIrqEn = 0, rxBatch = 0, errIrqEn = 0, errClear = 0;
  logic [AW-1:0] txThresh = '0, rxThresh = '0;
  logic txIrq, rxIrq, errIrq;

  int checks = 0;
  int errs = 0;
  logic [DW-1:0] txQ[$];
  logic [DW-1:0] rxQ[$];

  always #5 clk = ~clk;

  fifo_irq_pair #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN),
    .txPushReq(txPushReq), .txPushData(txPushData), .txPopReq(txPopReq),
    .txPopData(txPopData), .txLevel(txLevel), .txFull(txFull), .txEmpty(txEmpty),
    .rxPushReq(rxPushReq), .rxPushData(rxPushData), .rxPopReq(rxPopReq),
    .rxPopData(rxPopData), .rxLevel(rxLevel), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txIrqEn(txIrqEn), .txBatch(txBatch), .txThresh(txThresh),
    .rxIrqEn(rxIrqEn), .rxBatch(rxBatch), .rxThresh(rxThresh),
    .errIrqEn(errIrqEn), .errClear(errClear),
    .txIrq(txIrq), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushTx(input logic [DW-1:0] d);
    txPushReq = 1'b1; txPushData = d;
    if (txQ.size() < DEPTH) txQ.push_back(d);
    @(negedge clk);
    txPushReq = 1'b0;
  endtask

  task automatic pushRx(input logic [DW-1:0] d);
    rxPushReq = 1'b1; rxPushData = d;
    if (rxQ.size() < DEPTH) rxQ.push_back(d);
    @(negedge clk);
    rxPushReq = 1'b0;
  endtask

  task automatic popTx();
    txPopReq = 1'b1;
    @(negedge clk);
    txPopReq = 1'b0;
  endtask

  task automatic popRx();
    rxPopReq = 1'b1;
    @(negedge clk);
    rxPopReq = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // Monitors: compare retired heads against the scoreboard queues (R1)
  always @(posedge clk) begin
    if (rstN && txPopReq && txQ.size() > 0) begin
      logic [DW-1:0] e;
      e = txQ.pop_front();
      chk(txPopData == e, "R1 tx order", int'(txPopData), int'(e));
    end
  end

  always @(posedge clk) begin
    if (rstN && rxPopReq && rxQ.size() > 0) begin
      logic [DW-1:0] e;
      e = rxQ.pop_front();
      chk(rxPopData == e, "R1 rx order", int'(rxPopData), int'(e));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10 watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R10 reset state
    chk(txLevel == 0 && rxLevel == 0, "R10 reset level", int'(txLevel) + int'(rxLevel), 0);
    chk(txEmpty && rxEmpty && !txFull && !rxFull, "R10 reset flags", 0, 1);
    chk(!txIrq && !rxIrq && !errIrq, "R10 reset irqs", int'(txIrq | rxIrq | errIrq), 0);

    txIrqEn = 1'b1; tick(2);
    chk(txIrq == 1'b1, "R4 tx single empty", int'(txIrq), 1);
    rxIrqEn = 1'b1; tick(2);
    chk(rxIrq == 1'b0, "R6 rx single empty", int'(rxIrq), 0);

    pushRx(8'hA1);
    chk(rxLevel == 1, "R2 rx level", int'(rxLevel), 1);
    chk(rxIrq == 1'b0, "R10 irq lags level", int'(rxIrq), 0);
    tick(1);
    chk(rxIrq == 1'b1, "R6 rx single waiting", int'(rxIrq), 1);
    pushRx(8'hA2);
    pushRx(8'hA3);
    chk(rxLevel == 3, "R2 rx level 3", int'(rxLevel), 3);

    for (int i = 0; i < DEPTH; i++) pushTx(DW'(i * 7 + 3));
    chk(txFull && txLevel == DEPTH, "R2 tx full", int'(txLevel), DEPTH);
    tick(1);
    chk(txIrq == 1'b0, "R4 tx single full", int'(txIrq), 0);
    pushTx(8'hEE);
    chk(txLevel == DEPTH, "R3 overflow dropped", int'(txLevel), DEPTH);
    tick(2);
    chk(errIrq == 1'b0, "R8 err disabled", int'(errIrq), 0);
    errIrqEn = 1'b1; tick(2);
    chk(errIrq == 1'b1, "R9 err pending", int'(errIrq), 1);
    tick(3);
    chk(errIrq == 1'b1, "R9 err sticky", int'(errIrq), 1);
    errClear = 1'b1; tick(1); errClear = 1'b0; tick(2);
    chk(errIrq == 1'b0, "R9 err cleared", int'(errIrq), 0);

    for (int i = 0; i < DEPTH; i++) popTx();
    chk(txEmpty && txLevel == 0, "R2 tx drained", int'(txLevel), 0);
    popTx();
    chk(txLevel == 0, "R3 underflow level", int'(txLevel), 0);
    tick(2);
    chk(errIrq == 1'b1, "R9 underflow sets", int'(errIrq), 1);
    errClear = 1'b1; tick(1); errClear = 1'b0; tick(2);
    chk(errIrq == 1'b0, "R9 err cleared again", int'(errIrq), 0);

    txBatch = 1'b1; txThresh = 4'd4;
    for (int i = 0; i < 4; i++) pushTx(DW'(8'h40 + i));
    tick(2);
    chk(txIrq == 1'b1, "R5 tx at threshold", int'(txIrq), 1);
    pushTx(8'h44); tick(2);
    chk(txIrq == 1'b0, "R5 tx above threshold", int'(txIrq), 0);
    txThresh = 4'd5; tick(2);
    chk(txIrq == 1'b1, "R5 tx threshold raised", int'(txIrq), 1);

    txPushReq = 1'b1; txPopReq = 1'b1; txPushData = 8'h55; txQ.push_back(8'h55);
    tick(1);
    txPushReq = 1'b0; txPopReq = 1'b0;
    chk(txLevel == 5, "R2 push and pop", int'(txLevel), 5);

    rxBatch = 1'b1; rxThresh = 4'd2; tick(2);
    chk(rxIrq == 1'b1, "R7 rx above threshold", int'(rxIrq), 1);
    popRx();
    chk(rxLevel == 2, "R2 rx after pop", int'(rxLevel), 2);
    tick(2);
    chk(rxIrq == 1'b0, "R7 rx at threshold", int'(rxIrq), 0);
    rxThresh = 4'd15;
    for (int i = 0; i < 13; i++) pushRx(DW'(8'hB0 + i));
    tick(2);
    chk(rxIrq == 1'b0, "R7 rx level 15", int'(rxIrq), 0);
    pushRx(8'hC0); tick(2);
    chk(rxIrq == 1'b1, "R7 rx full above 15", int'(rxIrq), 1);

    rxIrqEn = 1'b0; tick(2);
    chk(rxIrq == 1'b0, "R8 rx disabled", int'(rxIrq), 0);
    txIrqEn = 1'b0; tick(2);
    chk(txIrq == 1'b0, "R8 tx disabled", int'(txIrq), 0);

    for (int i = 0; i < DEPTH; i++) popRx();
    for (int i = 0; i < 5; i++) popTx();
    chk(rxLevel == 0 && txLevel == 0, "R2 all drained", int'(rxLevel) + int'(txLevel), 0);
    chk(txQ.size() == 0 && rxQ.size() == 0, "R1 scoreboard empty",
        txQ.size() + rxQ.size(), 0);
    tick(2);
    summary();
    $finish;
  end
endmodule